// File: doc/BRIEF.md
# Queue Create/Delete Command Validator

This block screens the four administrative commands that build and tear down I/O submission and completion queues. It keeps one allocation bit per queue slot for submission queues and one per slot for completion queues. For each command it decides whether the command is legal. It then returns a status code and a do-not-retry flag. A legal command also sets or clears the matching allocation bit.

Every field arrives in parallel on a single command cycle qualified by `cmd_valid`. The verdict appears on the response port one clock later, registered. On success, exactly one update strobe pulses in that same response cycle, together with the affected queue id. The allocation table changes on the same clock edge that captures the response, so the command in the very next cycle already sees the new table. Slot 0 belongs to the admin queue and can never be created or deleted through this path.

Top module: `qcmd_validator`

## Requirements
- R1: Every cycle with `cmd_valid` high produces exactly one cycle of `rsp_valid` on the following cycle. A cycle without a command produces no response. The opcode encoding is 0 = create SQ, 1 = create CQ, 2 = delete SQ, 3 = delete CQ.
- R2: A queue id of 0 is refused by all four commands with status 0x02 (bad queue id), unless an earlier check in the R10 order has already failed.
- R3: Create SQ returns status 0x02 when its queue id is at or above `NUM_Q`, or when that submission queue is already allocated.
- R4: Create SQ returns status 0x01 (bad completion-queue reference) when its referenced CQ id is 0, is at or above `NUM_Q`, or names a completion queue that is not allocated.
- R5: Create CQ returns status 0x02 when its queue id is at or above `NUM_Q`, or when that completion queue is already allocated.
- R6: Delete SQ and delete CQ return status 0x02 when the named queue is not currently allocated, which includes any id at or above `NUM_Q`.
- R7: Both create commands return status 0x03 (bad size) when the queue size is 0 or greater than `cap_max_entries`.
- R8: Both create commands return status 0x04 (bad address) when any of the low `PAGE_SHIFT` bits of the base address is set (default 12 bits).
- R9: Create CQ returns status 0x05 (bad vector) when the interrupt vector is at or above `NUM_Q`. Create SQ ignores the vector.
- R10: Checks are ranked in a fixed order, and only the first failing one is reported: CQ reference, then queue id, then size, then address, then vector.
- R11: Success is status 0x00 with `rsp_dnr` low. Every nonzero status comes with `rsp_dnr` high.
- R12: On success, exactly one of `sq_set`, `cq_set`, `sq_clr`, `cq_clr` pulses in the response cycle, matching the opcode, and `upd_qid` carries the queue id. Without success, all four strobes are low and `upd_qid` is 0. A command in the next cycle sees the updated table.
- R13: Reset empties both allocation tables and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 0 create SQ, 1 create CQ, 2 delete SQ, 3 delete CQ |
| cmd_qid | input | ID_W | Queue id to create or delete |
| cmd_cqid | input | ID_W | Completion queue referenced by create SQ |
| cmd_qsize | input | ID_W | Requested queue size |
| cmd_vector | input | ID_W | Interrupt vector for create CQ |
| cmd_base | input | ADDR_W | Queue base address |
| cap_max_entries | input | ID_W | Largest queue size allowed |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 8 | Status code (0x00 to 0x05) |
| rsp_dnr | output | 1 | Do-not-retry flag |
| sq_set | output | 1 | Submission queue allocated |
| sq_clr | output | 1 | Submission queue released |
| cq_set | output | 1 | Completion queue allocated |
| cq_clr | output | 1 | Completion queue released |
| upd_qid | output | ID_W | Queue id of the table update |

## Verification
The case that matters most is a table update and a table lookup landing in the same cycle. This happens when a command that changes a slot is followed at once by a command that reads the same slot. Examples are create-then-create of one id, create CQ followed by create SQ that references it, and create followed by delete. The bench issues commands on consecutive cycles with no idle gap, and it updates its own allocation model as soon as each command is issued. The response of the second command must therefore reflect the first command's effect; a stale lookup shows up as a wrong status or a missing strobe.

// File: rtl/qv_pkg.sv
package qv_pkg;

  typedef enum logic [1:0] {
    OP_MK_SQ = 2'd0,
    OP_MK_CQ = 2'd1,
    OP_RM_SQ = 2'd2,
    OP_RM_CQ = 2'd3
  } qv_op_e;

  typedef enum logic [7:0] {
    ST_OK        = 8'h00,
    ST_BAD_CQREF = 8'h01,
    ST_BAD_QID   = 8'h02,
    ST_BAD_SIZE  = 8'h03,
    ST_BAD_ADDR  = 8'h04,
    ST_BAD_VEC   = 8'h05
  } qv_status_e;

  // One flag per rule; the field order here is not the priority order.
  typedef struct packed {
    logic vec_bad;
    logic addr_bad;
    logic size_bad;
    logic qid_bad;
    logic cqref_bad;
  } qv_fault_t;

  // First failing rule wins (R10).
  function automatic qv_status_e pick_status(input qv_fault_t f);
    if (f.cqref_bad)     return ST_BAD_CQREF;
    else if (f.qid_bad)  return ST_BAD_QID;
    else if (f.size_bad) return ST_BAD_SIZE;
    else if (f.addr_bad) return ST_BAD_ADDR;
    else if (f.vec_bad)  return ST_BAD_VEC;
    return ST_OK;
  endfunction

endpackage

// File: rtl/qv_alloc_map.sv
module qv_alloc_map #(
  parameter int NUM_Q = 64,
  parameter int ID_W  = 16,
  parameter int N_RD  = 1,
  localparam int IDX_W = $clog2(NUM_Q)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_en,
  input  logic                      clr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [N_RD-1:0][ID_W-1:0] rd_id,
  output logic [N_RD-1:0]           rd_hit
);

  localparam logic [ID_W-1:0] Q_LIMIT = ID_W'(NUM_Q);

  logic [NUM_Q-1:0] slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else begin
      for (int i = 0; i < NUM_Q; i++) begin
        if (set_en && wr_idx == IDX_W'(i))      slot[i] <= 1'b1;
        else if (clr_en && wr_idx == IDX_W'(i)) slot[i] <= 1'b0;
      end
    end
  end

  // Each lookup port: an out-of-range id never counts as allocated.
  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_hit[r] = (rd_id[r] < Q_LIMIT) && slot[rd_id[r][IDX_W-1:0]];
  end

endmodule

// File: rtl/qv_rules.sv
module qv_rules
  import qv_pkg::*;
#(
  parameter int NUM_Q      = 64,
  parameter int ID_W       = 16,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  qv_op_e            op,
  input  logic [ID_W-1:0]   qid,
  input  logic [ID_W-1:0]   cqid,
  input  logic [ID_W-1:0]   qsize,
  input  logic [ID_W-1:0]   vector,
  input  logic [ADDR_W-1:0] base,
  input  logic [ID_W-1:0]   max_entries,
  input  logic              sq_hit,
  input  logic              cq_hit,
  input  logic              cq_ref_hit,
  output qv_fault_t         fault
);

  localparam logic [ID_W-1:0]   Q_LIMIT   = ID_W'(NUM_Q);
  localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  logic qid_zero, qid_out, size_bad, addr_bad;

  assign qid_zero = (qid == '0);
  assign qid_out  = (qid >= Q_LIMIT);
  assign size_bad = (qsize == '0) || (qsize > max_entries);
  assign addr_bad = (base & PAGE_MASK) != '0;

  always_comb begin
    fault = '0;
    case (op)
      OP_MK_SQ: begin
        fault.cqref_bad = (cqid == '0) || !cq_ref_hit;
        fault.qid_bad   = qid_zero || qid_out || sq_hit;
        fault.size_bad  = size_bad;
        fault.addr_bad  = addr_bad;
      end
      OP_MK_CQ: begin
        fault.qid_bad   = qid_zero || qid_out || cq_hit;
        fault.size_bad  = size_bad;
        fault.addr_bad  = addr_bad;
        fault.vec_bad   = (vector >= Q_LIMIT);
      end
      OP_RM_SQ: fault.qid_bad = qid_zero || !sq_hit;
      OP_RM_CQ: fault.qid_bad = qid_zero || !cq_hit;
      default:  fault = '0;
    endcase
  end

endmodule

// File: rtl/qcmd_validator.sv
module qcmd_validator
  import qv_pkg::*;
#(
  parameter int NUM_Q      = 64,
  parameter int ID_W       = 16,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ID_W-1:0]   cmd_qid,
  input  logic [ID_W-1:0]   cmd_cqid,
  input  logic [ID_W-1:0]   cmd_qsize,
  input  logic [ID_W-1:0]   cmd_vector,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ID_W-1:0]   cap_max_entries,
  output logic              rsp_valid,
  output logic [7:0]        rsp_status,
  output logic              rsp_dnr,
  output logic              sq_set,
  output logic              sq_clr,
  output logic              cq_set,
  output logic              cq_clr,
  output logic [ID_W-1:0]   upd_qid
);

  localparam int IDX_W = $clog2(NUM_Q);

  qv_op_e     op;
  qv_fault_t  fault;
  qv_status_e verdict;

  // Named events for the checker.
  logic sq_qid_hit, cq_qid_hit, cq_ref_hit;
  logic accept;
  logic mk_sq_now, mk_cq_now, rm_sq_now, rm_cq_now;
  logic [1:0] cq_hits;

  assign op = qv_op_e'(cmd_op);

  qv_alloc_map #(.NUM_Q(NUM_Q), .ID_W(ID_W), .N_RD(1)) u_sq_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (mk_sq_now),
    .clr_en (rm_sq_now),
    .wr_idx (cmd_qid[IDX_W-1:0]),
    .rd_id  (cmd_qid),
    .rd_hit (sq_qid_hit)
  );

  // Port 0 looks up the command's own id, port 1 the referenced CQ.
  qv_alloc_map #(.NUM_Q(NUM_Q), .ID_W(ID_W), .N_RD(2)) u_cq_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (mk_cq_now),
    .clr_en (rm_cq_now),
    .wr_idx (cmd_qid[IDX_W-1:0]),
    .rd_id  ({cmd_cqid, cmd_qid}),
    .rd_hit (cq_hits)
  );

  assign cq_qid_hit = cq_hits[0];
  assign cq_ref_hit = cq_hits[1];

  qv_rules #(
    .NUM_Q(NUM_Q), .ID_W(ID_W), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_rules (
    .op          (op),
    .qid         (cmd_qid),
    .cqid        (cmd_cqid),
    .qsize       (cmd_qsize),
    .vector      (cmd_vector),
    .base        (cmd_base),
    .max_entries (cap_max_entries),
    .sq_hit      (sq_qid_hit),
    .cq_hit      (cq_qid_hit),
    .cq_ref_hit  (cq_ref_hit),
    .fault       (fault)
  );

  assign verdict   = pick_status(fault);
  assign accept    = cmd_valid && (verdict == ST_OK);
  assign mk_sq_now = accept && (op == OP_MK_SQ);
  assign mk_cq_now = accept && (op == OP_MK_CQ);
  assign rm_sq_now = accept && (op == OP_RM_SQ);
  assign rm_cq_now = accept && (op == OP_RM_CQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_dnr    <= 1'b0;
      sq_set     <= 1'b0;
      sq_clr     <= 1'b0;
      cq_set     <= 1'b0;
      cq_clr     <= 1'b0;
      upd_qid    <= '0;
    end else begin
      rsp_valid  <= cmd_valid;
      rsp_status <= cmd_valid ? 8'(verdict) : 8'h00;
      rsp_dnr    <= cmd_valid && (verdict != ST_OK);
      sq_set     <= mk_sq_now;
      sq_clr     <= rm_sq_now;
      cq_set     <= mk_cq_now;
      cq_clr     <= rm_cq_now;
      upd_qid    <= accept ? cmd_qid : '0;
    end
  end

endmodule

// File: rtl/qv_checker.sv
module qv_checker
  import qv_pkg::*;
#(
  parameter int NUM_Q = 64,
  parameter int ID_W  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [ID_W-1:0] cmd_vector,
  input logic            sq_used,
  input logic            cq_used,
  input logic            rsp_valid,
  input logic [7:0]      rsp_status,
  input logic            rsp_dnr,
  input logic            sq_set,
  input logic            sq_clr,
  input logic            cq_set,
  input logic            cq_clr,
  input logic [ID_W-1:0] upd_qid
);

  localparam logic [ID_W-1:0] Q_LIMIT = ID_W'(NUM_Q);

  logic [3:0] strobes;
  assign strobes = {sq_set, sq_clr, cq_set, cq_clr};

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  p_dnr_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_dnr == (rsp_status != 8'h00)));

  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  p_strobe_ok_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes != 4'b0) |-> (rsp_valid && rsp_status == 8'h00));

  p_admin_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes != 4'b0) |-> (upd_qid != '0));

  p_sq_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MK_SQ && sq_used) |=> !sq_set);

  p_cq_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MK_CQ && cq_used) |=> !cq_set);

  p_rm_needs_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RM_SQ && !sq_used) |=> !sq_clr);

  p_vector_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MK_CQ && cmd_vector >= Q_LIMIT) |=> !cq_set);

  p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (strobes == 4'b0 && !rsp_dnr));

endmodule

bind qcmd_validator qv_checker #(.NUM_Q(NUM_Q), .ID_W(ID_W)) u_qv_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_vector (cmd_vector),
  .sq_used    (sq_qid_hit),
  .cq_used    (cq_qid_hit),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_dnr    (rsp_dnr),
  .sq_set     (sq_set),
  .sq_clr     (sq_clr),
  .cq_set     (cq_set),
  .cq_clr     (cq_clr),
  .upd_qid    (upd_qid)
);

// File: tb/test_qcmd_validator.sv
module test_qcmd_validator;

  localparam int NQ   = 8;
  localparam int MAXE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [15:0] cmd_qid = '0, cmd_cqid = '0, cmd_qsize = '0, cmd_vector = '0;
  logic [63:0] cmd_base = '0;
  logic [15:0] cap_max_entries = 16'(MAXE);
  logic        rsp_valid, rsp_dnr, sq_set, sq_clr, cq_set, cq_clr;
  logic [7:0]  rsp_status;
  logic [15:0] upd_qid;

  qcmd_validator #(.NUM_Q(NQ), .ID_W(16), .ADDR_W(64), .PAGE_SHIFT(12)) i_qcmd_validator (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_qid(cmd_qid), .cmd_cqid(cmd_cqid), .cmd_qsize(cmd_qsize),
    .cmd_vector(cmd_vector), .cmd_base(cmd_base), .cap_max_entries(cap_max_entries),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_dnr(rsp_dnr),
    .sq_set(sq_set), .sq_clr(sq_clr), .cq_set(cq_set), .cq_clr(cq_clr),
    .upd_qid(upd_qid)
  );

  always #10 clk = ~clk;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  bit  sq_m [NQ];
  bit  cq_m [NQ];

  // Pending expectation for the response of the previously issued cycle.
  bit    p_valid = 1'b0;
  int    p_code  = 0;
  int    p_op    = 0;
  int    p_qid   = 0;
  string p_tag   = "R13";

  function automatic int model_code(int op, int qid, int cqid, int qs, longint base, int vec);
    bit ok_id;
    ok_id = (qid >= 1) && (qid < NQ);
    case (op)
      0: begin
        if (cqid < 1 || cqid >= NQ) return 1;
        if (!cq_m[cqid]) return 1;
        if (!ok_id) return 2;
        if (sq_m[qid]) return 2;
      end
      1: begin
        if (!ok_id) return 2;
        if (cq_m[qid]) return 2;
      end
      2: return (ok_id && sq_m[qid]) ? 0 : 2;
      default: return (ok_id && cq_m[qid]) ? 0 : 2;
    endcase
    if (qs == 0 || qs > MAXE) return 3;
    if ((base & 64'hFFF) != 0) return 4;
    if (op == 1 && vec >= NQ) return 5;
    return 0;
  endfunction

  task automatic check_prev();
    bit [3:0] want_str, got_str;
    int want_q;
    bit good;
    want_str = 4'b0;
    want_q = 0;
    if (p_valid && p_code == 0) begin
      want_str[3 - p_op] = 1'b1;
      want_q = p_qid;
    end
    got_str = {sq_set, cq_set, sq_clr, cq_clr};
    n_tests++;
    if (p_valid)
      good = rsp_valid && rsp_status == 8'(p_code) && rsp_dnr == (p_code != 0)
             && got_str == want_str && upd_qid == 16'(want_q);
    else
      good = !rsp_valid && got_str == 4'b0 && !rsp_dnr;
    if (!good)
      $display("FAIL %s: valid=%0b status=%0d dnr=%0b strobes=%b qid=%0d, expected valid=%0b status=%0d dnr=%0b strobes=%b qid=%0d",
               p_tag, rsp_valid, rsp_status, rsp_dnr, got_str, upd_qid,
               p_valid, p_code, (p_valid && p_code != 0), want_str, want_q);
    if (!good) n_fail++;
  endtask

  // Strobe bit order in check_prev: {sq_set, cq_set, sq_clr, cq_clr}, index 3-op.
  task automatic step(bit v, int op, int qid, int cqid, int qs, longint base, int vec, string tag);
    @(negedge clk);
    check_prev();
    p_valid = v;
    p_op = op;
    p_qid = qid;
    p_tag = v ? tag : "R1";
    p_code = 0;
    if (v) begin
      p_code = model_code(op, qid, cqid, qs, base, vec);
      if (p_code == 0) begin
        case (op)
          0: sq_m[qid] = 1'b1;
          1: cq_m[qid] = 1'b1;
          2: sq_m[qid] = 1'b0;
          default: cq_m[qid] = 1'b0;
        endcase
      end
    end
    cmd_valid  = v;
    cmd_op     = 2'(op);
    cmd_qid    = 16'(qid);
    cmd_cqid   = 16'(cqid);
    cmd_qsize  = 16'(qs);
    cmd_base   = 64'(base);
    cmd_vector = 16'(vec);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < NQ; i++) begin sq_m[i] = 1'b0; cq_m[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R13: outputs quiet under reset.
    n_tests++;
    if (rsp_valid || rsp_dnr || sq_set || sq_clr || cq_set || cq_clr || rsp_status != 0 || upd_qid != 0) begin
      n_fail++;
      $display("FAIL R13: outputs active in reset (valid=%0b status=%0d), expected all zero", rsp_valid, rsp_status);
    end
    rst_n = 1'b1;

    // R6 / R13: tables are empty after reset; every delete refused.
    for (int q = 0; q < NQ + 2; q++) step(1, 2, q, 0, 1, 0, 0, "R6");
    for (int q = 0; q < NQ + 2; q++) step(1, 3, q, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, "R1");

    // R2 / R5: create every CQ id, then repeat each (already allocated).
    for (int q = 0; q < NQ + 2; q++) step(1, 1, q, 0, 4, 64'h1000, 0, "R5");
    for (int q = 0; q < NQ + 2; q++) step(1, 1, q, 0, 4, 64'h2000, 1, "R2");

    // R3 / R4 / R10: create SQ over all id and CQ-reference pairs, back to back.
    for (int c = 0; c < NQ + 2; c++)
      for (int q = 0; q < NQ + 2; q++) step(1, 0, q, c, 2, 64'h3000, 99, "R4");

    // R12: create/delete pairs on the same id in consecutive cycles.
    for (int q = 1; q < NQ; q++) begin
      step(1, 2, q, 0, 1, 0, 0, "R12");
      step(1, 2, q, 0, 1, 0, 0, "R12");
      step(1, 0, q, q, 3, 0, 0, "R12");
      step(1, 3, q, 0, 1, 0, 0, "R12");
      step(1, 1, q, 0, 1, 0, 0, "R12");
    end

    // R7: size sweep on create CQ 3, freeing it after each attempt.
    for (int s = 0; s < MAXE + 4; s++) begin
      step(1, 3, 3, 0, 0, 0, 0, "R7");
      step(1, 1, 3, 0, s, 64'h8000, 2, "R7");
    end
    // R7 on create SQ.
    for (int s = 0; s < MAXE + 4; s++) begin
      step(1, 2, 5, 0, 0, 0, 0, "R7");
      step(1, 0, 5, 1, s, 64'h8000, 0, "R7");
    end

    // R8: one address bit at a time.
    for (int b = 0; b < 16; b++) begin
      step(1, 3, 4, 0, 0, 0, 0, "R8");
      step(1, 1, 4, 0, 5, longint'(64'h1) << b, 0, "R8");
      step(1, 2, 6, 0, 0, 0, 0, "R8");
      step(1, 0, 6, 2, 5, longint'(64'h1) << b, 0, "R8");
    end

    // R9: vector sweep.
    for (int v = 0; v < NQ + 4; v++) begin
      step(1, 3, 2, 0, 0, 0, 0, "R9");
      step(1, 1, 2, 0, 7, 64'h4000, v, "R9");
    end

    // R10 / R11: pseudo-random mixes with several faults at once.
    lfsr = 32'h1d2c3b4a;
    for (int n = 0; n < 4000; n++) begin
      int op, q, c, s, v;
      longint b;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      op = int'(lfsr[1:0]);
      q  = int'(lfsr[7:4]) % (NQ + 2);
      c  = int'(lfsr[11:8]) % (NQ + 2);
      s  = int'(lfsr[16:12]) % (MAXE + 4);
      v  = int'(lfsr[20:17]) % (NQ + 4);
      b  = lfsr[21] ? longint'({lfsr[31:24], 12'h000}) : longint'({lfsr[31:24], lfsr[23:22], 10'h001});
      if (lfsr[3:2] == 2'b00) step(0, 0, 0, 0, 0, 0, 0, "R1");
      else step(1, op, q, c, s, b, v, "R10");
    end

    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    done = 1'b1;
    summary();
  end

endmodule